// File: doc/BRIEF.md
# Zone Block Map with Wear-Levelling Free Rotation

This block holds the logical-to-physical translation for one zone of flash blocks. Each physical block belongs to exactly one of three groups: mapped to a logical index (the used group), waiting for reuse (the free group), or retired as defective (the bad group). Only logical indices below the used count can be addressed, so defective blocks stay hidden from whoever issues requests.

After reset, the block takes one initialization beat for each physical block, in ascending physical order. Each beat carries a flag that marks the block as defective. Good blocks fill the logical indices first, up to a capacity picked by a select input. Any good blocks left over go into the free group. Once every physical block has been presented, the block accepts three kinds of request. A lookup translates a logical index. A write remaps a logical index to the free block that has waited longest and returns both the old and the new physical numbers, so the caller can copy, program and erase. A retire reports that a mapped block has failed in service, swaps in a free block and counts the failed block as bad.

The free group is a circular queue. Blocks leave from the head and enter at the tail, so repeated writes to one logical index cycle through every free block before any block is used again.

Top module: `zone_map_table`

## Requirements
- R1: While reset is high and afterwards until the last of the NBLK initialization beats has been taken, op_ready and rsp_valid are low. used_count, free_count and bad_count read zero directly after reset.
- R2: Each cycle with init_valid high consumes the next physical block number, counting up from 0. A beat with init_bad high adds one to bad_count. A good beat is mapped to the next logical index while the used count is below capacity, and otherwise enters the tail of the free queue. Once ready, used_count + free_count + bad_count equals NBLK.
- R3: cap_sel gives the capacity: 0 gives 1000, 1 gives 900, 2 or 3 gives 500. The used count becomes the smaller of that capacity and the number of good blocks. A change of cap_sel after initialization has no effect.
- R4: op_code 0 (lookup) returns the physical block mapped to op_lidx on both rsp_old and rsp_new and changes nothing.
- R5: Any request whose op_lidx is at or above used_count responds with rsp_err high and rsp_old = rsp_new = 0, and leaves the map and all counts unchanged.
- R6: op_code 1 (write) returns the previous mapping on rsp_old and the free-queue head on rsp_new. The head becomes the new mapping and the previous block enters the free-queue tail, so free_count is unchanged.
- R7: Free blocks are handed out in the order they entered the queue. N+1 consecutive writes to one logical index, with N free blocks, return to the original physical block.
- R8: op_code 2 (retire) replaces the mapping with the free-queue head and reports the old and new blocks. The old block does not return to the free queue. bad_count rises by one and free_count falls by one.
- R9: A write or retire while free_count is zero responds with rsp_err and changes nothing.
- R10: op_code 3 is reserved and always responds with rsp_err and no change.
- R11: A request is taken on a clock edge where op_valid and op_ready are both high. op_ready is low in the following cycle. rsp_valid is high for exactly the one cycle after the next edge, and op_ready is high again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts initialization |
| cap_sel | input | 2 | Used-capacity select, read during initialization |
| init_valid | input | 1 | Initialization beat for the next physical block |
| init_bad | input | 1 | Marks the block of this beat as defective |
| op_ready | output | 1 | Block can take a request |
| op_valid | input | 1 | Request present |
| op_code | input | 2 | 0 lookup, 1 write, 2 retire, 3 reserved |
| op_lidx | input | AW | Logical block index of the request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Request rejected, nothing changed |
| rsp_old | output | AW | Physical block mapped before the request |
| rsp_new | output | AW | Physical block mapped after the request |
| used_count | output | CW | Number of addressable logical indices |
| free_count | output | CW | Number of blocks in the free queue |
| bad_count | output | CW | Number of retired or defective blocks |

## Verification
Three zones are built, each with a different defect pattern and capacity. One has the capacity as the limit and a deep free queue. One has fewer good blocks than the capacity, so its free queue is empty from the start. One has no defects and a shallow queue. Directed runs of writes to a single index show whether the queue gives out blocks in least-recently-freed order rather than most recent first. Retires that continue until the queue is empty separate the counting of the bad group from that of the free group. Random mixes of all four codes, with indices that sometimes fall just past the used count, are checked against a bench-side model of the map and the queue, which catches wrong pointer wrap, wrong bounds and stale read data.

// File: rtl/zmap_pkg.sv
package zmap_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_WRITE  = 2'd1,
    OP_RETIRE = 2'd2,
    OP_RSVD   = 2'd3
  } zmap_op_e;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_EXEC = 2'd2
  } zmap_state_e;
endpackage

// File: rtl/zmap_sdp_ram.sv
// Simple dual-port RAM, one write port and one registered read port.
module zmap_sdp_ram #(
  parameter int DW    = 10,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/zmap_free_fifo.sv
// Circular free-block queue: pop at head, push at tail, RAM-backed.
module zmap_free_fifo #(
  parameter int NBLK = 1024,
  localparam int AW  = $clog2(NBLK),
  localparam int CW  = $clog2(NBLK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_data,
  output logic [CW-1:0] count
);
  logic [AW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(NBLK - 1)) ? '0 : p + 1'b1;
  endfunction

  zmap_sdp_ram #(.DW(AW), .DEPTH(NBLK)) u_store (
    .clk   (clk),
    .we    (push),
    .waddr (tail_q),
    .wdata (push_data),
    .raddr (head_q),
    .rdata (head_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) tail_q <= wrap_inc(tail_q);
      if (pop)  head_q <= wrap_inc(head_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/zone_map_table.sv
module zone_map_table
  import zmap_pkg::*;
#(
  parameter int NBLK  = 1024,
  parameter int CAP_A = 1000,
  parameter int CAP_B = 900,
  parameter int CAP_C = 500,
  localparam int AW   = $clog2(NBLK),
  localparam int CW   = $clog2(NBLK + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    cap_sel,
  input  logic          init_valid,
  input  logic          init_bad,
  output logic          op_ready,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [AW-1:0] op_lidx,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [AW-1:0] rsp_old,
  output logic [AW-1:0] rsp_new,
  output logic [CW-1:0] used_count,
  output logic [CW-1:0] free_count,
  output logic [CW-1:0] bad_count
);
  zmap_state_e   state_q;
  logic [AW-1:0] scan_q;
  logic [CW-1:0] used_q, bad_q;
  zmap_op_e      op_q;
  logic [AW-1:0] lidx_q;

  logic          map_we;
  logic [AW-1:0] map_waddr, map_wdata, map_rdata;
  logic          fq_push, fq_pop;
  logic [AW-1:0] fq_push_data, fq_head;
  logic [CW-1:0] fq_count;
  logic [CW-1:0] cap_lim;
  logic          exec_err;
  logic          init_good;

  always_comb begin
    case (cap_sel)
      2'd0:    cap_lim = CW'(CAP_A);
      2'd1:    cap_lim = CW'(CAP_B);
      default: cap_lim = CW'(CAP_C);
    endcase
  end

  assign init_good = init_valid && !init_bad;

  assign exec_err = (CW'(lidx_q) >= used_q) || (op_q == OP_RSVD) ||
                    ((op_q != OP_LOOKUP) && (fq_count == '0));

  zmap_sdp_ram #(.DW(AW), .DEPTH(NBLK)) u_map (
    .clk   (clk),
    .we    (map_we),
    .waddr (map_waddr),
    .wdata (map_wdata),
    .raddr (op_lidx),
    .rdata (map_rdata)
  );

  zmap_free_fifo #(.NBLK(NBLK)) u_free (
    .clk       (clk),
    .rst       (rst),
    .push      (fq_push),
    .push_data (fq_push_data),
    .pop       (fq_pop),
    .head_data (fq_head),
    .count     (fq_count)
  );

  // Write-port steering for the map and the free queue.
  always_comb begin
    map_we       = 1'b0;
    map_waddr    = '0;
    map_wdata    = '0;
    fq_push      = 1'b0;
    fq_push_data = '0;
    fq_pop       = 1'b0;
    case (state_q)
      ST_INIT: begin
        if (init_good) begin
          if (used_q < cap_lim) begin
            map_we    = 1'b1;
            map_waddr = used_q[AW-1:0];
            map_wdata = scan_q;
          end else begin
            fq_push      = 1'b1;
            fq_push_data = scan_q;
          end
        end
      end
      ST_EXEC: begin
        if (!exec_err && op_q != OP_LOOKUP) begin
          map_we    = 1'b1;
          map_waddr = lidx_q;
          map_wdata = fq_head;
          fq_pop    = 1'b1;
          if (op_q == OP_WRITE) begin
            fq_push      = 1'b1;
            fq_push_data = map_rdata;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_INIT;
      scan_q    <= '0;
      used_q    <= '0;
      bad_q     <= '0;
      op_q      <= OP_LOOKUP;
      lidx_q    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_old   <= '0;
      rsp_new   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_INIT: begin
          if (init_valid) begin
            if (init_bad)             bad_q  <= bad_q + 1'b1;
            else if (used_q < cap_lim) used_q <= used_q + 1'b1;
            scan_q <= scan_q + 1'b1;
            if (scan_q == AW'(NBLK - 1)) state_q <= ST_IDLE;
          end
        end
        ST_IDLE: begin
          if (op_valid) begin
            op_q    <= zmap_op_e'(op_code);
            lidx_q  <= op_lidx;
            state_q <= ST_EXEC;
          end
        end
        ST_EXEC: begin
          rsp_valid <= 1'b1;
          rsp_err   <= exec_err;
          if (exec_err) begin
            rsp_old <= '0;
            rsp_new <= '0;
          end else begin
            rsp_old <= map_rdata;
            rsp_new <= (op_q == OP_LOOKUP) ? map_rdata : fq_head;
            if (op_q == OP_RETIRE) bad_q <= bad_q + 1'b1;
          end
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_INIT;
      endcase
    end
  end

  assign op_ready   = (state_q == ST_IDLE);
  assign used_count = used_q;
  assign free_count = fq_count;
  assign bad_count  = bad_q;
endmodule

// File: rtl/zmap_checker.sv
module zmap_checker #(
  parameter int NBLK = 1024,
  localparam int AW  = $clog2(NBLK),
  localparam int CW  = $clog2(NBLK + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          op_valid,
  input logic          op_ready,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [AW-1:0] rsp_old,
  input logic [AW-1:0] rsp_new,
  input logic [CW-1:0] used_count,
  input logic [CW-1:0] free_count,
  input logic [CW-1:0] bad_count
);
  logic [CW+1:0] total;
  assign total = (CW+2)'(used_count) + (CW+2)'(free_count) + (CW+2)'(bad_count);

  assert_partition_R2: assert property (@(posedge clk) disable iff (rst)
    op_ready |-> total == (CW+2)'(NBLK));

  assert_used_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    $past(op_ready) |-> used_count == $past(used_count));

  assert_err_nochange_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (free_count == $past(free_count) &&
                                bad_count == $past(bad_count) &&
                                used_count == $past(used_count)));

  assert_err_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> (rsp_old == '0 && rsp_new == '0));

  assert_retire_counts_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && bad_count != $past(bad_count)) |->
      (bad_count == $past(bad_count) + 1'b1 && free_count == $past(free_count) - 1'b1));

  assert_busy_after_take_R11: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready) |=> (!op_ready && !rsp_valid));

  assert_rsp_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind zone_map_table zmap_checker #(.NBLK(NBLK)) u_zmap_chk (
  .clk        (clk),
  .rst        (rst),
  .op_valid   (op_valid),
  .op_ready   (op_ready),
  .rsp_valid  (rsp_valid),
  .rsp_err    (rsp_err),
  .rsp_old    (rsp_old),
  .rsp_new    (rsp_new),
  .used_count (used_count),
  .free_count (free_count),
  .bad_count  (bad_count)
);

// File: tb/zone_map_table_test.sv
module zone_map_table_test;
  localparam int NB = 1024;
  localparam int AW = 10;
  localparam int CW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    cap_sel = 2'd0;
  logic          init_valid = 1'b0;
  logic          init_bad = 1'b0;
  logic          op_ready;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = 2'd0;
  logic [AW-1:0] op_lidx = '0;
  logic          rsp_valid, rsp_err;
  logic [AW-1:0] rsp_old, rsp_new;
  logic [CW-1:0] used_count, free_count, bad_count;

  always #4 clk = ~clk;

  zone_map_table uut (
    .clk(clk), .rst(rst), .cap_sel(cap_sel), .init_valid(init_valid),
    .init_bad(init_bad), .op_ready(op_ready), .op_valid(op_valid),
    .op_code(op_code), .op_lidx(op_lidx), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_old(rsp_old), .rsp_new(rsp_new),
    .used_count(used_count), .free_count(free_count), .bad_count(bad_count)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Reference model
  int mapm [NB];
  int fq [$];
  int used_m, bad_m;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic int cap_of(input int sel);
    if (sel == 0) return 1000;
    if (sel == 1) return 900;
    return 500;
  endfunction

  function automatic bit is_bad(input int pat, input int p);
    if (pat == 0) return (p % 37) == 5;
    if (pat == 1) return (p % 40) == 3;
    return 1'b0;
  endfunction

  task automatic check_counts(input string tag);
    check({tag, " used_count"}, int'(used_count), used_m);
    check({tag, " free_count"}, int'(free_count), fq.size());
    check({tag, " bad_count"},  int'(bad_count),  bad_m);
  endtask

  task automatic reset_and_init(input int sel, input int pat);
    int cap;
    rst = 1'b1;
    init_valid = 1'b0;
    op_valid = 1'b0;
    cap_sel = 2'(sel);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 op_ready after reset", int'(op_ready), 0);
    check("R1 rsp_valid after reset", int'(rsp_valid), 0);
    check("R1 used_count after reset", int'(used_count), 0);
    check("R1 free_count after reset", int'(free_count), 0);
    check("R1 bad_count after reset", int'(bad_count), 0);
    cap = cap_of(sel);
    used_m = 0; bad_m = 0; fq.delete();
    for (int p = 0; p < NB; p++) begin
      if (p % 97 == 50) begin
        init_valid = 1'b0;
        @(negedge clk);
      end
      if (p == NB - 1) check("R1 not ready before last beat", int'(op_ready), 0);
      init_valid = 1'b1;
      init_bad = is_bad(pat, p);
      if (is_bad(pat, p)) bad_m++;
      else if (used_m < cap) begin mapm[used_m] = p; used_m++; end
      else fq.push_back(p);
      @(negedge clk);
    end
    init_valid = 1'b0;
    init_bad = 1'b0;
    check("R1 ready after init", int'(op_ready), 1);
    check_counts("R2 R3 after init");
  endtask

  task automatic do_op(input int code, input int l);
    bit e;
    int eo, en;
    e = (l >= used_m) || (code == 3) || (code != 0 && fq.size() == 0);
    eo = 0; en = 0;
    if (!e) begin
      eo = mapm[l];
      if (code == 0) en = eo;
      else begin
        en = fq.pop_front();
        mapm[l] = en;
        if (code == 1) fq.push_back(eo);
        else bad_m++;
      end
    end
    op_valid = 1'b1;
    op_code = 2'(code);
    op_lidx = AW'(l);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0;
    check("R11 busy after accept", int'(op_ready), 0);
    check("R11 no early rsp", int'(rsp_valid), 0);
    @(negedge clk);
    check("R11 rsp_valid", int'(rsp_valid), 1);
    check("R11 ready again", int'(op_ready), 1);
    if (code == 3) check("R10 reserved err", int'(rsp_err), 1);
    else if (l >= used_m) check("R5 range err", int'(rsp_err), 1);
    else if (code != 0 && e) check("R9 empty err", int'(rsp_err), 1);
    else check("R4 R6 R8 no err", int'(rsp_err), 0);
    check(code == 0 ? "R4 lookup old" : (code == 1 ? "R6 write old" : "R8 retire old"),
          int'(rsp_old), eo);
    check(code == 0 ? "R4 lookup new" : (code == 1 ? "R7 write new" : "R8 retire new"),
          int'(rsp_new), en);
    check_counts(e ? "R5 R9 counts after err" : "R6 R8 counts");
    @(negedge clk);
    check("R11 single pulse", int'(rsp_valid), 0);
  endtask

  initial begin
    int unsigned seed_dummy;
    int first, l;
    seed_dummy = $urandom(32'd20240611);
    @(negedge clk);

    // Zone A: capacity 500, deep free queue
    reset_and_init(2, 0);
    check("R3 cap 500 used", int'(used_count), 500);
    check("R2 first mapping", mapm[0], 0);
    for (int i = 0; i < 8; i++) do_op(0, i * 61);
    do_op(0, 499);
    do_op(0, 500);
    do_op(0, 1023);
    // rotation through whole free queue on one index
    first = mapm[7];
    for (int i = 0; i <= fq.size(); i++) do_op(1, 7);
    check("R7 rotation returns home", mapm[7], first);
    do_op(0, 7);
    cap_sel = 2'd0;  // ignored after init
    @(negedge clk);
    check("R3 cap change ignored", int'(used_count), 500);
    do_op(0, 600);
    do_op(3, 3);
    do_op(2, 10);
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 16);
      l = int'($urandom % (used_m + 8));
      if (r < 5) do_op(0, l);
      else if (r < 12) do_op(1, l);
      else if (r < 15) do_op(2, l);
      else do_op(3, l);
    end

    // Zone B: fewer good blocks than capacity, empty queue
    reset_and_init(0, 1);
    check("R3 used limited by good", int'(used_count), 998);
    do_op(1, 5);
    do_op(2, 5);
    do_op(0, 997);
    do_op(0, 998);

    // Zone C: no defects, capacity 900, retire to empty
    reset_and_init(1, 2);
    check("R3 cap 900 used", int'(used_count), 900);
    while (fq.size() > 0) do_op(2, int'($urandom % 900));
    do_op(1, 0);
    do_op(2, 899);
    do_op(0, 899);
    for (int i = 0; i < 200; i++) do_op(int'($urandom % 4), int'($urandom % 910));

    done = 1'b1;
    finish_run();
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule